// File: doc/BRIEF.md
# Threshold-Binned Synapse Programming Pulse Controller

This block sits between the learning engine and the write drivers of an analogue resistive synapse array. Every weight is stored as the difference between a positive cell and a negative cell. For each synapse the learning engine hands over one signed update value together with the synapse's row and column. The block turns that value into a burst of programming pulses, and the burst length is chosen by where the update's magnitude lies relative to two programmable limits. Small updates fall in a dead zone and produce no pulse at all. Mid-sized updates usually produce one pulse. Large updates produce a long burst, typically around 150 pulses.

The sign of the update selects the polarity. A positive value raises conductance (a SET pulse) and a negative value lowers it (a RESET pulse). Which cell of the differential pair receives the burst is chosen by a pseudo-random bit. That bit comes from a 16-bit linear feedback shift register that advances once for every update the block accepts.

The pulse width and the idle gap between pulses are both given in clock cycles. At 125 MHz, a 50 ns pulse is about six cycles. A mode input selects one of three schemes. The first ignores the limits and sends one pulse for any non-zero value. The second uses only the lower limit. The third uses both limits with a programmable count per interval. The burst lengths in the third scheme, typically 0, 1 and 150, and the limits, typically the codes for 1 µS and 10 µS of conductance change, are inputs supplied by the surrounding logic.

Top module: `wtu_pulse_ctrl`

## Requirements
- R1: While and after reset, with no update accepted, `busy_o`, `done_o`, `pulse_set_o` and `pulse_reset_o` are 0 and `upd_ready_o` is 1.
- R2: An update with the sign bit clear asserts only `pulse_set_o`, and an update with the sign bit set asserts only `pulse_reset_o`. The polarity does not change within a burst.
- R3: With `cfg_mode_i` = 2, the burst length depends on the magnitude |delta|:
  - |delta| < `cfg_thr_lo_i` gives `cfg_cnt_lo_i` pulses.
  - `cfg_thr_lo_i` ≤ |delta| < `cfg_thr_hi_i` gives `cfg_cnt_mid_i` pulses.
  - |delta| ≥ `cfg_thr_hi_i` gives `cfg_cnt_hi_i` pulses.
  - Each limit belongs to the interval above it. Mode 3 behaves exactly as mode 2.
- R4: With `cfg_mode_i` = 1, an update issues one pulse if |delta| ≥ `cfg_thr_lo_i` and none otherwise.
- R5: With `cfg_mode_i` = 0, an update issues one pulse if delta is non-zero and none if it is zero.
- R6: Each pulse is high for exactly max(`cfg_width_i`,1) consecutive cycles. The first pulse begins in the cycle right after the accepting clock edge.
- R7: Consecutive pulses are separated by exactly max(`cfg_gap_i`,1) low cycles. `busy_o` is therefore high for N·W + (N−1)·G cycles for N pulses, where W and G are the effective width and gap.
- R8: An update that yields zero pulses raises `done_o` in the first cycle after acceptance. It asserts no pulse output and never raises `busy_o`.
- R9:
  - `done_o` is high for exactly one cycle, in the cycle after the last pulse cycle, and `busy_o` is low in that cycle.
  - `upd_ready_o` equals the inverse of `busy_o`.
  - An update presented while busy is ignored: it does not change the burst in progress, and it does not advance the random sequence.
- R10: The LFSR is seeded with 16'hACE1. It shifts left, and its new bit 0 is the XOR of bits 15, 13, 12 and 10. The cell-select output `pulse_neg_cell_o` takes the current bit 0 on each accepted update, and the register shifts once per accepted update, including updates that yield zero pulses. A value of 1 selects the negative cell.
- R11: `pulse_row_o`, `pulse_col_o` and `pulse_neg_cell_o` show the accepted update's values from the cycle after acceptance and hold them steady while busy.
- R12: The most negative delta (16'h8000) has magnitude 32768 and falls in the top interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid_i | input | 1 | Update offered this cycle |
| upd_ready_o | output | 1 | Block can take an update |
| upd_delta_i | input | DW (16) | Signed two's-complement weight update |
| upd_row_i | input | ROW_W (7) | Synapse row |
| upd_col_i | input | COL_W (3) | Synapse column |
| cfg_mode_i | input | 2 | 0: any non-zero, 1: one limit, 2/3: two limits |
| cfg_thr_lo_i | input | DW | Lower magnitude limit |
| cfg_thr_hi_i | input | DW | Upper magnitude limit |
| cfg_cnt_lo_i | input | CW (8) | Pulses below the lower limit (mode 2) |
| cfg_cnt_mid_i | input | CW | Pulses between the limits (mode 2) |
| cfg_cnt_hi_i | input | CW | Pulses at or above the upper limit (mode 2) |
| cfg_width_i | input | TW (8) | Pulse width in cycles (0 treated as 1) |
| cfg_gap_i | input | TW | Idle gap in cycles (0 treated as 1) |
| pulse_set_o | output | 1 | Conductance-increase pulse enable |
| pulse_reset_o | output | 1 | Conductance-decrease pulse enable |
| pulse_neg_cell_o | output | 1 | 1: negative cell of the pair, 0: positive cell |
| pulse_row_o | output | ROW_W | Row of the synapse being programmed |
| pulse_col_o | output | COL_W | Column of the synapse being programmed |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-update strobe |

## Verification
The properties assume two things about the inputs:
- the configuration inputs stay constant while a burst is running;
- reset is held from time zero until the first edges have passed.

Under those assumptions they can treat the polarity and the address as frozen for the whole burst. The stimulus respects this by changing width, gap, counts and mode only after `done_o` has been seen. It presents new updates only when the block is idle, except in one deliberate case: a second update is offered during a burst to confirm that the block ignores it.

// File: rtl/wtu_pkg.sv
package wtu_pkg;

    typedef enum logic [1:0] {
        SCHEME_ANY_NZ  = 2'd0,
        SCHEME_ONE_LIM = 2'd1,
        SCHEME_TWO_LIM = 2'd2,
        SCHEME_TWO_ALT = 2'd3
    } scheme_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_PULSE = 2'd1,
        SQ_GAP   = 2'd2
    } seq_state_e;

    localparam int          RNG_W    = 16;
    localparam logic [15:0] RNG_SEED = 16'hACE1;
    localparam logic [15:0] RNG_TAPS = 16'hB400;

    function automatic logic [15:0] rng_step(input logic [15:0] q);
        return {q[14:0], ^(q & RNG_TAPS)};
    endfunction

endpackage

// File: rtl/wtu_ladder.sv
module wtu_ladder
    import wtu_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic [1:0]    mode_i,
    input  logic [DW-1:0] delta_i,
    input  logic [DW-1:0] thr_lo_i,
    input  logic [DW-1:0] thr_hi_i,
    input  logic [CW-1:0] cnt_lo_i,
    input  logic [CW-1:0] cnt_mid_i,
    input  logic [CW-1:0] cnt_hi_i,
    output logic [CW-1:0] count_o,
    output logic          raise_o
);

    localparam logic [CW-1:0] ONE_PULSE = CW'(1);
    localparam logic [CW-1:0] NO_PULSE  = '0;

    logic [DW-1:0] mag;
    logic          nonzero;
    logic          ge_lo;
    logic          ge_hi;
    scheme_e       scheme;

    always_comb begin
        mag     = delta_i[DW-1] ? (~delta_i + DW'(1)) : delta_i;
        nonzero = |delta_i;
        ge_lo   = (mag >= thr_lo_i);
        ge_hi   = (mag >= thr_hi_i);
        scheme  = scheme_e'(mode_i);
        raise_o = ~delta_i[DW-1];
    end

    always_comb begin
        unique case (scheme)
            SCHEME_ANY_NZ:  count_o = nonzero ? ONE_PULSE : NO_PULSE;
            SCHEME_ONE_LIM: count_o = ge_lo ? ONE_PULSE : NO_PULSE;
            default: begin
                if (ge_hi)      count_o = cnt_hi_i;
                else if (ge_lo) count_o = cnt_mid_i;
                else            count_o = cnt_lo_i;
            end
        endcase
    end

endmodule

// File: rtl/wtu_rng.sv
module wtu_rng
    import wtu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    output logic bit_o
);

    logic [RNG_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)         q <= RNG_SEED;
        else if (step_i) q <= rng_step(q);
    end

    assign bit_o = q[0];

endmodule

// File: rtl/wtu_sequencer.sv
module wtu_sequencer
    import wtu_pkg::*;
#(
    parameter int CW = 8,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [CW-1:0] count_i,
    input  logic [TW-1:0] width_i,
    input  logic [TW-1:0] gap_i,
    output logic          pulse_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam logic [TW-1:0] T_ONE = TW'(1);
    localparam logic [CW-1:0] C_ONE = CW'(1);

    seq_state_e    st;
    logic [TW-1:0] tmr;
    logic [CW-1:0] left;
    logic [TW-1:0] wid_q;
    logic [TW-1:0] gap_q;
    logic          done_q;
    logic [TW-1:0] wid_eff;
    logic [TW-1:0] gap_eff;

    always_comb begin
        wid_eff = (width_i == '0) ? T_ONE : width_i;
        gap_eff = (gap_i == '0) ? T_ONE : gap_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            tmr    <= '0;
            left   <= '0;
            wid_q  <= T_ONE;
            gap_q  <= T_ONE;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                SQ_IDLE: begin
                    if (start_i) begin
                        if (count_i == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            st    <= SQ_PULSE;
                            tmr   <= wid_eff - T_ONE;
                            left  <= count_i;
                            wid_q <= wid_eff;
                            gap_q <= gap_eff;
                        end
                    end
                end
                SQ_PULSE: begin
                    if (tmr == '0) begin
                        if (left == C_ONE) begin
                            st     <= SQ_IDLE;
                            left   <= '0;
                            done_q <= 1'b1;
                        end else begin
                            st   <= SQ_GAP;
                            tmr  <= gap_q - T_ONE;
                            left <= left - C_ONE;
                        end
                    end else begin
                        tmr <= tmr - T_ONE;
                    end
                end
                SQ_GAP: begin
                    if (tmr == '0) begin
                        st  <= SQ_PULSE;
                        tmr <= wid_q - T_ONE;
                    end else begin
                        tmr <= tmr - T_ONE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign pulse_o = (st == SQ_PULSE);
    assign busy_o  = (st != SQ_IDLE);
    assign done_o  = done_q;

endmodule

// File: rtl/wtu_pulse_ctrl.sv
module wtu_pulse_ctrl
    import wtu_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 8,
    parameter int TW    = 8,
    parameter int ROW_W = 7,
    parameter int COL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_valid_i,
    output logic             upd_ready_o,
    input  logic [DW-1:0]    upd_delta_i,
    input  logic [ROW_W-1:0] upd_row_i,
    input  logic [COL_W-1:0] upd_col_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic [DW-1:0]    cfg_thr_lo_i,
    input  logic [DW-1:0]    cfg_thr_hi_i,
    input  logic [CW-1:0]    cfg_cnt_lo_i,
    input  logic [CW-1:0]    cfg_cnt_mid_i,
    input  logic [CW-1:0]    cfg_cnt_hi_i,
    input  logic [TW-1:0]    cfg_width_i,
    input  logic [TW-1:0]    cfg_gap_i,
    output logic             pulse_set_o,
    output logic             pulse_reset_o,
    output logic             pulse_neg_cell_o,
    output logic [ROW_W-1:0] pulse_row_o,
    output logic [COL_W-1:0] pulse_col_o,
    output logic             busy_o,
    output logic             done_o
);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             neg_cell;
        logic             raise;
    } target_t;

    logic          accept;
    logic [CW-1:0] n_pulses;
    logic          raise;
    logic          rng_bit;
    logic          seq_pulse;
    logic          seq_busy;
    logic          seq_done;
    target_t       tgt_q;

    assign accept = upd_valid_i & ~seq_busy;

    wtu_ladder #(.DW(DW), .CW(CW)) u_ladder (
        .mode_i    (cfg_mode_i),
        .delta_i   (upd_delta_i),
        .thr_lo_i  (cfg_thr_lo_i),
        .thr_hi_i  (cfg_thr_hi_i),
        .cnt_lo_i  (cfg_cnt_lo_i),
        .cnt_mid_i (cfg_cnt_mid_i),
        .cnt_hi_i  (cfg_cnt_hi_i),
        .count_o   (n_pulses),
        .raise_o   (raise)
    );

    wtu_rng u_rng (
        .clk    (clk),
        .rst    (rst),
        .step_i (accept),
        .bit_o  (rng_bit)
    );

    wtu_sequencer #(.CW(CW), .TW(TW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (accept),
        .count_i (n_pulses),
        .width_i (cfg_width_i),
        .gap_i   (cfg_gap_i),
        .pulse_o (seq_pulse),
        .busy_o  (seq_busy),
        .done_o  (seq_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= '0;
        end else if (accept) begin
            tgt_q.row      <= upd_row_i;
            tgt_q.col      <= upd_col_i;
            tgt_q.neg_cell <= rng_bit;
            tgt_q.raise    <= raise;
        end
    end

    assign upd_ready_o      = ~seq_busy;
    assign pulse_set_o      = seq_pulse & tgt_q.raise;
    assign pulse_reset_o    = seq_pulse & ~tgt_q.raise;
    assign pulse_neg_cell_o = tgt_q.neg_cell;
    assign pulse_row_o      = tgt_q.row;
    assign pulse_col_o      = tgt_q.col;
    assign busy_o           = seq_busy;
    assign done_o           = seq_done;

endmodule

// File: rtl/wtu_pulse_ctrl_chk.sv
module wtu_pulse_ctrl_chk #(
    parameter int ROW_W = 7,
    parameter int COL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             upd_ready_o,
    input logic             pulse_set_o,
    input logic             pulse_reset_o,
    input logic             pulse_neg_cell_o,
    input logic [ROW_W-1:0] pulse_row_o,
    input logic [COL_W-1:0] pulse_col_o,
    input logic             busy_o,
    input logic             done_o
);

    AST_POLARITY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pulse_set_o && pulse_reset_o)); // R2

    AST_POLARITY_HELD: assert property (@(posedge clk) disable iff (rst)
        (pulse_set_o && $past(busy_o) && busy_o) |-> !$past(pulse_reset_o)); // R2

    AST_PULSE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (pulse_set_o || pulse_reset_o) |-> busy_o); // R6

    AST_BURST_OPENS_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (pulse_set_o || pulse_reset_o)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && upd_ready_o)); // R9

    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |->
            ($stable(pulse_row_o) && $stable(pulse_col_o) && $stable(pulse_neg_cell_o))); // R11

endmodule

bind wtu_pulse_ctrl wtu_pulse_ctrl_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .upd_ready_o      (upd_ready_o),
    .pulse_set_o      (pulse_set_o),
    .pulse_reset_o    (pulse_reset_o),
    .pulse_neg_cell_o (pulse_neg_cell_o),
    .pulse_row_o      (pulse_row_o),
    .pulse_col_o      (pulse_col_o),
    .busy_o           (busy_o),
    .done_o           (done_o)
);

// File: tb/sim_wtu_pulse_ctrl.sv
module sim_wtu_pulse_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_valid = 1'b0;
    logic        upd_ready;
    logic [15:0] upd_delta = '0;
    logic [6:0]  upd_row = '0;
    logic [2:0]  upd_col = '0;
    logic [1:0]  cfg_mode = 2'd2;
    logic [15:0] cfg_thr_lo = 16'd100;
    logic [15:0] cfg_thr_hi = 16'd1000;
    logic [7:0]  cfg_cnt_lo = 8'd0;
    logic [7:0]  cfg_cnt_mid = 8'd1;
    logic [7:0]  cfg_cnt_hi = 8'd4;
    logic [7:0]  cfg_width = 8'd2;
    logic [7:0]  cfg_gap = 8'd1;
    logic        p_set, p_reset, p_neg;
    logic [6:0]  p_row;
    logic [2:0]  p_col;
    logic        busy, done;

    int checks = 0;
    int fails  = 0;
    logic [15:0] rng_m = 16'hACE1;

    always #4 clk = ~clk;

    wtu_pulse_ctrl u0 (
        .clk(clk), .rst(rst),
        .upd_valid_i(upd_valid), .upd_ready_o(upd_ready),
        .upd_delta_i(upd_delta), .upd_row_i(upd_row), .upd_col_i(upd_col),
        .cfg_mode_i(cfg_mode), .cfg_thr_lo_i(cfg_thr_lo), .cfg_thr_hi_i(cfg_thr_hi),
        .cfg_cnt_lo_i(cfg_cnt_lo), .cfg_cnt_mid_i(cfg_cnt_mid), .cfg_cnt_hi_i(cfg_cnt_hi),
        .cfg_width_i(cfg_width), .cfg_gap_i(cfg_gap),
        .pulse_set_o(p_set), .pulse_reset_o(p_reset), .pulse_neg_cell_o(p_neg),
        .pulse_row_o(p_row), .pulse_col_o(p_col),
        .busy_o(busy), .done_o(done)
    );

    // {mode[1:0], delta[15:0], expected pulses[7:0]} with lo=100, hi=1000, counts 0/1/4
    localparam logic [25:0] VEC [16] = '{
        {2'd2, 16'd50,    8'd0},   // R3 dead zone
        {2'd2, 16'd99,    8'd0},   // R3 just below lower limit
        {2'd2, 16'd100,   8'd1},   // R3 lower limit inclusive
        {2'd2, 16'hFF9C,  8'd1},   // R2 -100 -> reset polarity
        {2'd2, 16'd999,   8'd1},   // R3 just below upper limit
        {2'd2, 16'd1000,  8'd4},   // R3 upper limit inclusive
        {2'd2, 16'hEC78,  8'd4},   // R2 -5000
        {2'd2, 16'h8000,  8'd4},   // R12 most negative
        {2'd1, 16'd100,   8'd1},   // R4
        {2'd1, 16'hFF9D,  8'd0},   // R4 -99
        {2'd1, 16'd20000, 8'd1},   // R4 large still one
        {2'd0, 16'd1,     8'd1},   // R5
        {2'd0, 16'd0,     8'd0},   // R5 zero
        {2'd0, 16'hFFFF,  8'd1},   // R5 -1
        {2'd3, 16'd1000,  8'd4},   // R3 mode 3 as mode 2
        {2'd2, 16'd0,     8'd0}    // R8 zero in mode 2
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rng_next(input logic [15:0] q);
        return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
    endfunction

    task automatic run(input logic [1:0] m, input logic [15:0] d,
                       input logic [6:0] r, input logic [2:0] c,
                       input int exp_n, input bit poke, input string tag);
        int w_eff, g_eff, exp_busy, k, hi_set, hi_rst, edges;
        logic prev, exp_cell, first_neg;
        logic [6:0] first_row;
        logic [2:0] first_col;
        w_eff = (cfg_width == 0) ? 1 : int'(cfg_width);
        g_eff = (cfg_gap == 0) ? 1 : int'(cfg_gap);
        exp_busy = (exp_n == 0) ? 0 : exp_n * w_eff + (exp_n - 1) * g_eff;
        exp_cell = rng_m[0];
        rng_m = rng_next(rng_m);
        @(negedge clk);
        chk(upd_ready == 1'b1, {tag, " R9 ready before offer"}, int'(upd_ready), 1);
        cfg_mode = m; upd_delta = d; upd_row = r; upd_col = c; upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
        first_neg = p_neg; first_row = p_row; first_col = p_col;
        k = 0; hi_set = 0; hi_rst = 0; edges = 0; prev = 1'b0;
        while (!done && k < 5000) begin
            if (p_set) hi_set++;
            if (p_reset) hi_rst++;
            if ((p_set | p_reset) && !prev) edges++;
            prev = p_set | p_reset;
            if (p_row != r || p_col != c)
                chk(1'b0, {tag, " R11 address held"}, int'(p_row), int'(r));
            if (poke && k == 1 && busy) begin
                upd_delta = 16'd1000; upd_valid = 1'b1;
            end else begin
                upd_valid = 1'b0;
            end
            k++;
            @(negedge clk);
        end
        upd_valid = 1'b0;
        chk(done == 1'b1, {tag, " R9 done reached"}, int'(done), 1);
        chk(busy == 1'b0 && !p_set && !p_reset, {tag, " R9 idle at done"}, int'(busy), 0);
        chk(k == exp_busy, {tag, " R7 busy cycles"}, k, exp_busy);
        chk(edges == exp_n, {tag, " R3 pulse count"}, edges, exp_n);
        if (!d[15])
            chk(hi_set == exp_n * w_eff && hi_rst == 0, {tag, " R2/R6 set cycles"}, hi_set, exp_n * w_eff);
        else
            chk(hi_rst == exp_n * w_eff && hi_set == 0, {tag, " R2/R6 reset cycles"}, hi_rst, exp_n * w_eff);
        chk(first_neg == exp_cell, {tag, " R10 cell select"}, int'(first_neg), int'(exp_cell));
        chk(first_row == r && first_col == c, {tag, " R11 address"}, int'(first_row), int'(r));
        @(negedge clk);
        chk(done == 1'b0, {tag, " R9 done single"}, int'(done), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(!busy && !done && !p_set && !p_reset && upd_ready, "R1 in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !p_set && !p_reset && upd_ready, "R1 after reset", int'(done), 0);

        for (int i = 0; i < 16; i++) begin
            run(VEC[i][25:24], VEC[i][23:8], 7'((i * 5) % 128), 3'(i % 8),
                int'(VEC[i][7:0]), 1'b0, $sformatf("vec%0d", i));
        end

        // R3 long burst at upper interval, 150 pulses, ~50 ns pulses
        cfg_cnt_hi = 8'd150; cfg_width = 8'd6; cfg_gap = 8'd2;
        run(2'd2, 16'd2000, 7'd127, 3'd7, 150, 1'b0, "long R3");

        // R3 programmable dead-zone count
        cfg_cnt_lo = 8'd2; cfg_cnt_hi = 8'd4; cfg_width = 8'd3; cfg_gap = 8'd4;
        run(2'd2, 16'hFFF6, 7'd3, 3'd1, 2, 1'b0, "lowcnt R3");
        cfg_cnt_lo = 8'd0;

        // R6 R7 zero width and gap treated as one
        cfg_width = 8'd0; cfg_gap = 8'd0;
        run(2'd2, 16'd1000, 7'd9, 3'd2, 4, 1'b0, "clamp R6 R7");

        // R9 update offered while busy is ignored
        cfg_width = 8'd2; cfg_gap = 8'd1;
        run(2'd2, 16'hFC18, 7'd40, 3'd5, 4, 1'b1, "poke R9");
        // R10 sequence not advanced by the ignored offer
        run(2'd0, 16'd5, 7'd41, 3'd6, 1, 1'b0, "after poke R10");
        run(2'd1, 16'd1, 7'd42, 3'd0, 0, 1'b0, "zero R8");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule